// File: doc/BRIEF.md
# Relative-Select Edge Timing Unit

This unit measures the timing of one or two digital inputs for a single pin slot in a bank of 64 pins. Each of its two measured inputs, called A and B here, is chosen from the whole 64-bit pin bus. The choice is a small signed offset from the unit's own pin index, and the selection wraps around the ends of the bus. Every input is registered once, and rising edges are found by comparing that registered value with its value one clock earlier.

The unit has three measuring modes:

- It can add up the clocks in which A is high over a programmable window of N clocks.
- It can time each A period, from one A rise to the next.
- It can time the interval from an A rise to the B rise that follows it.

When a measurement completes, the unit loads it into the result register and pulses the done output for one clock. The result holds until the next measurement completes. All counters saturate at all-ones and never wrap.

A hold input freezes the measuring state. Many units can then be set up one at a time and released on the same clock. The mode, the offsets and the window length are expected to change only while reset is applied.

Top module: `edge_timer_unit`

## Requirements
- R1: The A input is pin (SELF_IDX + a_off_i) mod 64 and the B input is pin (SELF_IDX + b_off_i) mod 64. Each offset is a 3-bit two's-complement value from -4 to +3. For example, with SELF_IDX = 0, offset 3'b111 selects pin 63, 3'b110 selects pin 62 and 3'b011 selects pin 3.
- R2: When mode_i = 2'b00, the unit counts the clocks in which A is high over each window of period_i consecutive clocks. A period_i of 0 acts as 1. At the end of every window the count is latched into result_o and the count clears.
- R3: When mode_i = 2'b01, each A rise after the first latches the number of clocks since the previous A rise. No period is skipped. The first A rise after reset only arms the measurement.
- R4: When mode_i = 2'b10, the unit waits for an A rise and then for a B rise, and latches the number of clocks between the two. A rises while it waits for B are ignored. B rises while it waits for A are ignored.
- R5: When mode_i = 2'b11, the unit produces no results.
- R6: Counters and results saturate at 2^CW-1 and do not wrap.
- R7: While hold_i is high, the measuring state is frozen: no result is latched and done_o stays low. After release, counting resumes exactly where it stopped, so a window that starts at reset ends period_i clocks after release.
- R8: After reset, result_o is 0 and done_o is 0. done_o is a one-clock pulse in the same cycle in which result_o takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NPINS | Pin bus that A and B are selected from |
| mode_i | input | 2 | 00 high time, 01 A period, 10 A to B, 11 off |
| a_off_i | input | OFFW | Signed offset that selects A |
| b_off_i | input | OFFW | Signed offset that selects B |
| period_i | input | CW | Window length in clocks for mode 00 |
| hold_i | input | 1 | Freezes the measuring state while high |
| result_o | output | CW | Last completed measurement |
| done_o | output | 1 | One-clock pulse when result_o updates |

## Verification
The bench selects inputs through negative offsets from pin 0. A design that zero-extends the offset or forgets the wrap would watch the wrong pin and report nothing.

An irregular A train with periods 7, 4 and 5 exposes a period mode that loses a clock at each restart or skips alternate periods. In A-to-B mode, a repeated A rise before B and a stray B rise before A catch a design that restarts its count or finishes on the wrong edge.

The bench times the first window after a release to the exact cycle, so a freeze that leaks counts shows up. It also holds A low far beyond the counter range, so a counter that wraps returns a small value instead of all-ones.

// File: rtl/etu_pkg.sv
// Shared types for the edge timing unit.
package etu_pkg;
    typedef enum logic [1:0] {
        MODE_HIGH = 2'b00,
        MODE_PER  = 2'b01,
        MODE_ATOB = 2'b10,
        MODE_OFF  = 2'b11
    } etu_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } etu_state_e;
endpackage

// File: rtl/etu_pin_pick.sv
// Chooses one bit of the pin bus at a signed offset from a fixed own index.
// Assumes NPINS is a power of two, so the modulo is a plain truncation.
module etu_pin_pick #(
    parameter int NPINS    = 64,
    parameter int OFFW     = 3,
    parameter int SELF_IDX = 0
) (
    input  logic [NPINS-1:0] pins_i,
    input  logic [OFFW-1:0]  off_i,
    output logic             bit_o
);
    localparam int IW = $clog2(NPINS);
    localparam logic [IW-1:0] SELF_V = IW'(SELF_IDX);

    logic [IW-1:0] idx;

    // Sign-extend the offset and add modulo NPINS.
    always_comb begin
        idx   = SELF_V + {{(IW-OFFW){off_i[OFFW-1]}}, off_i};
        bit_o = pins_i[idx];
    end
endmodule

// File: rtl/etu_sampler.sv
// Registers each selected input and keeps its previous registered value,
// so that a later stage can detect edges. Runs even while frozen.
module etu_sampler #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] d_i,
    output logic [NCH-1:0] cur_o,
    output logic [NCH-1:0] prev_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            // Two-stage history for one channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cur_o[gi]  <= 1'b0;
                    prev_o[gi] <= 1'b0;
                end else begin
                    cur_o[gi]  <= d_i[gi];
                    prev_o[gi] <= cur_o[gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/etu_core.sv
// Measuring state machine: high-time accumulation, A period, A-to-B interval.
// Channel 0 is A and channel 1 is B. Assumes mode and period change only in reset.
module etu_core #(
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  etu_pkg::etu_mode_e mode_i,
    input  logic            hold_i,
    input  logic [CW-1:0]   period_i,
    input  logic [1:0]      cur_i,
    input  logic [1:0]      prev_i,
    output logic [CW-1:0]   result_o,
    output logic            done_o
);
    import etu_pkg::*;

    localparam logic [CW-1:0] MAXV = '1;

    etu_state_e    st_q;
    logic [CW-1:0] cnt_q, acc_q, acc_nx, result_q;
    logic          done_q, rise_a, rise_b, win_end;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == MAXV) ? v : v + 1'b1;
    endfunction

    // Edge flags and the next accumulator value.
    always_comb begin
        rise_a  = cur_i[0] & ~prev_i[0];
        rise_b  = cur_i[1] & ~prev_i[1];
        acc_nx  = cur_i[0] ? sat_inc(acc_q) : acc_q;
        win_end = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, period_i};
    end

    // Per-mode measurement sequencing with freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            acc_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!hold_i) begin
                unique case (mode_i)
                    MODE_HIGH: begin
                        if (win_end) begin
                            result_q <= acc_nx;
                            done_q   <= 1'b1;
                            acc_q    <= '0;
                            cnt_q    <= '0;
                        end else begin
                            acc_q <= acc_nx;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    MODE_PER: begin
                        if (rise_a) begin
                            if (st_q == ST_RUN) begin
                                result_q <= cnt_q;
                                done_q   <= 1'b1;
                            end
                            cnt_q <= CW'(1);
                            st_q  <= ST_RUN;
                        end else if (st_q == ST_RUN) begin
                            cnt_q <= sat_inc(cnt_q);
                        end
                    end
                    MODE_ATOB: begin
                        if (st_q == ST_IDLE) begin
                            if (rise_a) begin
                                cnt_q <= CW'(1);
                                st_q  <= ST_RUN;
                            end
                        end else if (rise_b) begin
                            result_q <= cnt_q;
                            done_q   <= 1'b1;
                            st_q     <= ST_IDLE;
                        end else begin
                            cnt_q <= sat_inc(cnt_q);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

    // R7: a frozen cycle produces no result.
    p_freeze_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!done_q && $stable(result_q)));

    // R3: two A periods can never end on adjacent clocks.
    p_period_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PER && done_q) |=> !done_q);

    // R4: after an interval result the unit is waiting for A again.
    p_atob_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ATOB && done_q) |-> st_q == ST_IDLE);

    // R6: timing results are never a wrapped zero.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_HIGH && done_q) |-> result_q != '0);

    // R2: a high-time total cannot exceed the window length.
    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HIGH && done_q) |->
            result_q <= ((period_i == '0) ? CW'(1) : period_i));
endmodule

// File: rtl/edge_timer_unit.sv
// Top of the edge timing unit: two relative pin pickers, an input sampler
// and the measuring core. Assumes configuration is static outside reset.
module edge_timer_unit #(
    parameter int NPINS    = 64,
    parameter int OFFW     = 3,
    parameter int CW       = 32,
    parameter int SELF_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    input  logic [1:0]       mode_i,
    input  logic [OFFW-1:0]  a_off_i,
    input  logic [OFFW-1:0]  b_off_i,
    input  logic [CW-1:0]    period_i,
    input  logic             hold_i,
    output logic [CW-1:0]    result_o,
    output logic             done_o
);
    localparam int NCH = 2;

    logic [OFFW-1:0] offs [NCH];
    logic [NCH-1:0]  sel, cur, prev;

    assign offs[0] = a_off_i;
    assign offs[1] = b_off_i;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_pick
            etu_pin_pick #(
                .NPINS(NPINS), .OFFW(OFFW), .SELF_IDX(SELF_IDX)
            ) u_pick (
                .pins_i(pins_i), .off_i(offs[gi]), .bit_o(sel[gi])
            );
        end
    endgenerate

    etu_sampler #(.NCH(NCH)) u_samp (
        .clk(clk), .rst_n(rst_n), .d_i(sel), .cur_o(cur), .prev_o(prev)
    );

    etu_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n),
        .mode_i(etu_pkg::etu_mode_e'(mode_i)),
        .hold_i(hold_i), .period_i(period_i),
        .cur_i(cur), .prev_i(prev),
        .result_o(result_o), .done_o(done_o)
    );
endmodule

// File: tb/edge_timer_unit_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module edge_timer_unit_tb_top;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   pins = '0;
    logic [1:0]    mode = 2'b00;
    logic [2:0]    a_off = 3'b111;
    logic [2:0]    b_off = 3'b011;
    logic [CW-1:0] period = '0;
    logic          hold = 1'b0;
    logic [CW-1:0] result;
    logic          done;

    int vectors = 0;
    int errors  = 0;
    int n_res   = 0;
    int res_log [32];
    int a_pin = 63;
    int b_pin = 3;

    edge_timer_unit #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .mode_i(mode),
        .a_off_i(a_off), .b_off_i(b_off), .period_i(period), .hold_i(hold),
        .result_o(result), .done_o(done)
    );

    always #5 clk = ~clk;

    // Collect every completed result.
    always @(negedge clk) begin
        if (rst_n && done && n_res < 32) begin
            res_log[n_res] = int'(result);
            n_res = n_res + 1;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [CW-1:0] per,
                            input logic h);
        @(negedge clk);
        rst_n = 1'b0; mode = m; period = per; hold = h; pins = '0;
        @(negedge clk);
        @(negedge clk);
        n_res = 0;
        rst_n = 1'b1;
    endtask

    task automatic drv(input logic a, input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pins[a_pin] = a;
            pins[b_pin] = b;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 reset result", int'(result), 0);
        chk("R8 reset done", int'(done), 0);
    endtask

    task automatic t_period();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b01, '0, 1'b0);
        drv(1, 0, 1); drv(0, 0, 6);
        drv(1, 0, 1); drv(0, 0, 3);
        drv(1, 0, 1); drv(0, 0, 4);
        drv(1, 0, 1); drv(0, 0, 3);
        #1;
        chk("R3 R1 result count", n_res, 3);
        chk("R3 period 7", res_log[0], 7);
        chk("R3 period 4", res_log[1], 4);
        chk("R3 period 5", res_log[2], 5);
    endtask

    task automatic t_atob();
        a_off = 3'b110; b_off = 3'b011; a_pin = 62; b_pin = 3;
        do_reset(2'b10, '0, 1'b0);
        drv(1, 0, 1); drv(0, 0, 4); drv(0, 1, 1); drv(0, 0, 3);
        drv(1, 0, 1); drv(0, 0, 2); drv(1, 0, 1); drv(0, 0, 4);
        drv(0, 1, 1); drv(0, 0, 3);
        drv(0, 1, 1); drv(0, 0, 2);
        drv(1, 0, 1); drv(0, 0, 3); drv(0, 1, 1); drv(0, 0, 3);
        #1;
        chk("R4 R1 result count", n_res, 3);
        chk("R4 interval 5", res_log[0], 5);
        chk("R4 repeat A ignored", res_log[1], 8);
        chk("R4 early B ignored", res_log[2], 4);
    endtask

    task automatic t_duty();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b00, CW'(20), 1'b0);
        for (int k = 0; k < 20; k++) begin
            drv(1, 0, 2); drv(0, 0, 3);
        end
        #1;
        chk("R2 window count", int'(n_res >= 4), 1);
        chk("R2 high time w1", res_log[1], 8);
        chk("R2 high time w2", res_log[2], 8);
        chk("R2 high time w3", res_log[3], 8);
    endtask

    task automatic t_period_zero();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b00, '0, 1'b0);
        drv(1, 0, 12);
        #1;
        chk("R2 zero window count", int'(n_res >= 8), 1);
        chk("R2 zero window value", res_log[5], 1);
    endtask

    task automatic t_freeze();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b00, CW'(10), 1'b1);
        drv(1, 0, 20);
        #1;
        chk("R7 no result while held", n_res, 0);
        chk("R7 result held at 0", int'(result), 0);
        @(negedge clk);
        hold = 1'b0;
        repeat (9) @(negedge clk);
        #1;
        chk("R7 no early window", n_res, 0);
        @(negedge clk);
        #1;
        chk("R7 first window on time", n_res, 1);
        chk("R7 first window value", res_log[0], 10);
    endtask

    task automatic t_off();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b11, CW'(4), 1'b0);
        for (int k = 0; k < 10; k++) begin
            drv(1, 1, 2); drv(0, 0, 2);
        end
        #1;
        chk("R5 off no results", n_res, 0);
        chk("R5 off result stays 0", int'(result), 0);
    endtask

    task automatic t_sat();
        a_off = 3'b111; a_pin = 63; b_pin = 3;
        do_reset(2'b01, '0, 1'b0);
        drv(1, 0, 1); drv(0, 0, 1100);
        drv(1, 0, 1); drv(0, 0, 3);
        #1;
        chk("R6 saturated count", n_res, 1);
        chk("R6 saturated value", res_log[0], 1023);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_period();
        t_atob();
        t_duty();
        t_period_zero();
        t_freeze();
        t_off();
        t_sat();
        summary();
    end
endmodule